// File: doc/BRIEF.md
# Named Split-Phase Barrier Unit

This block synchronises a group of processors through a small set of barriers, each picked by a short index. A barrier is used in two steps. First a processor posts an arrival and keeps running. Later the same processor asks to wait on that barrier. The wait is held off until every processor in the barrier's participant group has arrived. Arrival and waiting are separate requests, so a processor can do useful work between them. Every barrier keeps its own participant mask, its own arrival record and its own phase bit, so several barriers can be in use at the same time without affecting each other.

When the last participant arrives, three things happen at the same clock edge. The barrier's phase bit toggles, its arrival record is cleared, and a one-cycle completion pulse is broadcast on that barrier's line. Each processor holds its wait request as a level. The release output for a processor is high while its wait is pending and the barrier's phase differs from the phase that processor recorded when it last arrived. A second arrival for the same barrier within one phase is reported on a per-processor error pulse and has no other effect.

Top module: `barrier_unit`

## Requirements
- R1: After reset all participant masks are zero, all arrival records are clear and all phase bits are 0, and `waitRelease`, `doneBcast` and `dupErr` are all low.
- R2: A configuration write loads `cfgMask` into barrier `cfgBar` and clears that barrier's arrival record. In the same cycle, arrivals aimed at that barrier are discarded: they are not recorded, do not complete it and raise no error.
- R3: An arrival is a single-cycle pulse on `sigValid[p]` with the barrier index on `sigBar[p*2 +: 2]` (processor p uses bits 2p+1 down to 2p). It has no handshake and never stalls the processor.
- R4: A barrier completes at the clock edge where its recorded arrivals, together with that cycle's accepted arrivals, cover a non-zero participant mask. Several arrivals in the same cycle count together. `doneBcast[b]` is high for the one cycle that follows that edge. At the same edge the arrival record is cleared, so the next arrival starts a new phase.
- R5: `waitRelease[p]` is high only while `waitValid[p]` is high. It is driven combinationally from the registered phase state and the wait barrier index on `waitBar[p*2 +: 2]`, so a release caused by a completion appears in the cycle after the completing edge.
- R6: A wait posted before the barrier has completed in the processor's current phase keeps `waitRelease[p]` low.
- R7: A wait posted after the processor's phase has already completed is released at once, without blocking.
- R8: If a participant signals a barrier it has already arrived at in the current phase, `dupErr[p]` pulses high in the next cycle and the arrival is ignored.
- R9: Arrivals from processors outside a barrier's mask are ignored and raise no error. A barrier whose mask is zero never completes.
- R10: Each barrier's mask, arrival record and phase are independent of those of every other barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write the participant mask of one barrier |
| cfgBar | input | 2 | Barrier selected by the configuration write |
| cfgMask | input | 4 | Participant mask, one bit per processor |
| sigValid | input | 4 | Per-processor arrival pulse |
| sigBar | input | 8 | Per-processor arrival barrier index, 2 bits each |
| waitValid | input | 4 | Per-processor wait request, held as a level |
| waitBar | input | 8 | Per-processor wait barrier index, 2 bits each |
| waitRelease | output | 4 | Per-processor release of the pending wait |
| doneBcast | output | 4 | One-cycle completion pulse, one line per barrier |
| dupErr | output | 4 | One-cycle duplicate-arrival error per processor |

## Verification
All state updates happen at a single edge, and `doneBcast` and `dupErr` come from registers. Both therefore answer an arrival in the cycle right after the edge that captured it. `waitRelease` has no register of its own: it combines the state updated at that same edge with the wait request held during the following cycle. The bench drives every stimulus on the falling edge, lets one rising edge capture it, and samples all three outputs shortly after that rising edge. Each step is then checked on the cycle in which its results are due. The step that follows each error or completion checks that the pulse has dropped again.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  parameter int PROC_CNT = 4;
  parameter int BAR_CNT  = 4;
  localparam int BAR_W   = (BAR_CNT > 1) ? $clog2(BAR_CNT) : 1;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic [BAR_CNT-1:0][PROC_CNT-1:0] arrSet;   // arrivals to record
    logic [BAR_CNT-1:0]               cfgLoad;  // load mask, clear record
    logic [BAR_CNT-1:0]               complete; // flip phase, clear record
    logic [PROC_CNT-1:0]              accept;   // processor arrival accepted
    logic [PROC_CNT-1:0]              dup;      // repeated arrival
  } ctl_t;
endpackage

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
(
  input  logic [PROC_CNT-1:0]               sigValid,
  input  logic [PROC_CNT*BAR_W-1:0]         sigBar,
  input  logic                              cfgWe,
  input  logic [BAR_W-1:0]                  cfgBar,
  input  logic [BAR_CNT-1:0][PROC_CNT-1:0]  arrState,
  input  logic [BAR_CNT-1:0][PROC_CNT-1:0]  maskState,
  output ctl_t                              ctl
);
  logic [BAR_CNT-1:0][PROC_CNT-1:0] covered;

  always_comb begin
    ctl = '0;
    for (int b = 0; b < BAR_CNT; b++) begin
      ctl.cfgLoad[b] = cfgWe && (cfgBar == BAR_W'(b));
    end
    for (int p = 0; p < PROC_CNT; p++) begin
      for (int b = 0; b < BAR_CNT; b++) begin
        if (sigValid[p] && (sigBar[p*BAR_W +: BAR_W] == BAR_W'(b)) &&
            !ctl.cfgLoad[b] && maskState[b][p]) begin
          if (arrState[b][p]) begin
            ctl.dup[p] = 1'b1;
          end else begin
            ctl.arrSet[b][p] = 1'b1;
            ctl.accept[p]    = 1'b1;
          end
        end
      end
    end
    for (int b = 0; b < BAR_CNT; b++) begin
      covered[b]      = (arrState[b] | ctl.arrSet[b]) & maskState[b];
      ctl.complete[b] = !ctl.cfgLoad[b] && (maskState[b] != '0) &&
                        (covered[b] == maskState[b]);
    end
  end
endmodule

// File: rtl/barrier_dp.sv
module barrier_dp
  import barrier_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  ctl_t                              ctl,
  input  logic [PROC_CNT-1:0]               cfgMask,
  input  logic [PROC_CNT*BAR_W-1:0]         sigBar,
  input  logic [PROC_CNT-1:0]               waitValid,
  input  logic [PROC_CNT*BAR_W-1:0]         waitBar,
  output logic [BAR_CNT-1:0][PROC_CNT-1:0]  arrState,
  output logic [BAR_CNT-1:0][PROC_CNT-1:0]  maskState,
  output logic [PROC_CNT-1:0]               waitRelease,
  output logic [BAR_CNT-1:0]                doneBcast,
  output logic [PROC_CNT-1:0]               dupErr
);
  logic [BAR_CNT-1:0]                phaseQ;
  logic [PROC_CNT-1:0][BAR_CNT-1:0]  capQ;

  for (genvar b = 0; b < BAR_CNT; b++) begin : g_bar
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskState[b] <= '0;
        arrState[b]  <= '0;
        phaseQ[b]    <= 1'b0;
      end else if (ctl.cfgLoad[b]) begin
        maskState[b] <= cfgMask;
        arrState[b]  <= '0;
      end else if (ctl.complete[b]) begin
        arrState[b]  <= '0;
        phaseQ[b]    <= ~phaseQ[b];
      end else begin
        arrState[b]  <= arrState[b] | ctl.arrSet[b];
      end
    end
  end

  for (genvar p = 0; p < PROC_CNT; p++) begin : g_proc
    logic [BAR_W-1:0] sigIdx;
    logic [BAR_W-1:0] waitIdx;
    assign sigIdx  = sigBar[p*BAR_W +: BAR_W];
    assign waitIdx = waitBar[p*BAR_W +: BAR_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        capQ[p] <= '0;
      end else if (ctl.accept[p]) begin
        capQ[p][sigIdx] <= phaseQ[sigIdx];
      end
    end

    assign waitRelease[p] = waitValid[p] && (phaseQ[waitIdx] != capQ[p][waitIdx]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneBcast <= '0;
      dupErr    <= '0;
    end else begin
      doneBcast <= ctl.complete;
      dupErr    <= ctl.dup;
    end
  end
endmodule

// File: rtl/barrier_unit.sv
module barrier_unit
  import barrier_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [BAR_W-1:0]           cfgBar,
  input  logic [PROC_CNT-1:0]        cfgMask,
  input  logic [PROC_CNT-1:0]        sigValid,
  input  logic [PROC_CNT*BAR_W-1:0]  sigBar,
  input  logic [PROC_CNT-1:0]        waitValid,
  input  logic [PROC_CNT*BAR_W-1:0]  waitBar,
  output logic [PROC_CNT-1:0]        waitRelease,
  output logic [BAR_CNT-1:0]         doneBcast,
  output logic [PROC_CNT-1:0]        dupErr
);
  ctl_t                              ctl;
  logic [BAR_CNT-1:0][PROC_CNT-1:0]  arrState;
  logic [BAR_CNT-1:0][PROC_CNT-1:0]  maskState;

  barrier_ctrl u_ctrl (
    .sigValid  (sigValid),
    .sigBar    (sigBar),
    .cfgWe     (cfgWe),
    .cfgBar    (cfgBar),
    .arrState  (arrState),
    .maskState (maskState),
    .ctl       (ctl)
  );

  barrier_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cfgMask     (cfgMask),
    .sigBar      (sigBar),
    .waitValid   (waitValid),
    .waitBar     (waitBar),
    .arrState    (arrState),
    .maskState   (maskState),
    .waitRelease (waitRelease),
    .doneBcast   (doneBcast),
    .dupErr      (dupErr)
  );
endmodule

// File: rtl/barrier_unit_chk.sv
module barrier_unit_chk
  import barrier_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWe,
  input logic [BAR_W-1:0]     cfgBar,
  input logic [PROC_CNT-1:0]  sigValid,
  input logic [PROC_CNT-1:0]  waitValid,
  input logic [PROC_CNT-1:0]  waitRelease,
  input logic [BAR_CNT-1:0]   doneBcast,
  input logic [PROC_CNT-1:0]  dupErr
);
  // R8
  dup_needs_signal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dupErr != '0) |-> ((dupErr & ~$past(sigValid)) == '0));

  // R5
  release_needs_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitRelease & ~waitValid) == '0);

  // R4
  done_needs_signal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneBcast != '0) |-> ($past(sigValid) != '0));

  // R2
  cfg_blocks_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWe) |-> !doneBcast[$past(cfgBar)]);
endmodule

bind barrier_unit barrier_unit_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWe       (cfgWe),
  .cfgBar      (cfgBar),
  .sigValid    (sigValid),
  .waitValid   (waitValid),
  .waitRelease (waitRelease),
  .doneBcast   (doneBcast),
  .dupErr      (dupErr)
);

// File: tb/barrier_unit_test.sv
module barrier_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       cw;
    logic [1:0] cb;
    logic [3:0] cm;
    logic [3:0] sv;
    logic [7:0] sb;
    logic [3:0] wv;
    logic [7:0] wb;
    logic [3:0] rel;
    logic [3:0] done;
    logic [3:0] dup;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 4'b1111, 4'b0000, 8'h00, 4'b0000, 8'h00, 4'b0000, 4'b0000, 4'b0000},
    '{1'b1, 2'd1, 4'b0011, 4'b0000, 8'h00, 4'b0000, 8'h00, 4'b0000, 4'b0000, 4'b0000},
    '{1'b0, 2'd0, 4'b0000, 4'b0001, 8'h00, 4'b0000, 8'h00, 4'b0000, 4'b0000, 4'b0000},
    '{1'b0, 2'd0, 4'b0000, 4'b0011, 8'h04, 4'b0000, 8'h00, 4'b0000, 4'b0000, 4'b0001},
    '{1'b0, 2'd0, 4'b0000, 4'b0110, 8'h00, 4'b0001, 8'h00, 4'b0000, 4'b0000, 4'b0000},
    '{1'b0, 2'd0, 4'b0000, 4'b1000, 8'h00, 4'b0011, 8'h04, 4'b0001, 4'b0001, 4'b0000},
    '{1'b0, 2'd0, 4'b0000, 4'b0001, 8'h00, 4'b0001, 8'h00, 4'b0000, 4'b0000, 4'b0000},
    '{1'b0, 2'd0, 4'b0000, 4'b0001, 8'h01, 4'b0010, 8'h04, 4'b0010, 4'b0010, 4'b0000},
    '{1'b0, 2'd0, 4'b0000, 4'b0100, 8'h10, 4'b0100, 8'h00, 4'b0100, 4'b0000, 4'b0000},
    '{1'b0, 2'd0, 4'b0000, 4'b0010, 8'h08, 4'b0010, 8'h08, 4'b0000, 4'b0000, 4'b0000}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWe;
  logic [1:0] cfgBar;
  logic [3:0] cfgMask;
  logic [3:0] sigValid;
  logic [7:0] sigBar;
  logic [3:0] waitValid;
  logic [7:0] waitBar;
  logic [3:0] waitRelease;
  logic [3:0] doneBcast;
  logic [3:0] dupErr;

  int  total = 0;
  int  bad   = 0;
  bit  ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrier_unit uut (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgBar      (cfgBar),
    .cfgMask     (cfgMask),
    .sigValid    (sigValid),
    .sigBar      (sigBar),
    .waitValid   (waitValid),
    .waitBar     (waitBar),
    .waitRelease (waitRelease),
    .doneBcast   (doneBcast),
    .dupErr      (dupErr)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive on the falling edge, capture on the rising edge, sample just after it
  task automatic runVec(input vec_t v, input string lbl);
    @(negedge clk);
    cfgWe     = v.cw;
    cfgBar    = v.cb;
    cfgMask   = v.cm;
    sigValid  = v.sv;
    sigBar    = v.sb;
    waitValid = v.wv;
    waitBar   = v.wb;
    @(posedge clk);
    #2;
    check({lbl, " R5 R6 R7 waitRelease"}, waitRelease, v.rel);
    check({lbl, " R4 R10 doneBcast"}, doneBcast, v.done);
    check({lbl, " R8 R9 dupErr"}, dupErr, v.dup);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgBar = '0; cfgMask = '0;
    sigValid = '0; sigBar = '0; waitValid = '0; waitBar = '0;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset, even with a wait request present
    waitValid = 4'b1111;
    #1;
    check("R1 reset waitRelease", waitRelease, 4'b0000);
    check("R1 reset doneBcast", doneBcast, 4'b0000);
    check("R1 reset dupErr", dupErr, 4'b0000);
    waitValid = '0;
    rstN = 1'b1;

    // R3: arrivals are single-cycle pulses; the table walks the main function
    for (int i = 0; i < NVEC; i++) begin
      runVec(VECS[i], $sformatf("vec%0d", i));
    end

    // R2: a configuration write clears barrier 0 arrivals (p0 had arrived)
    runVec('{1'b1, 2'd0, 4'b0001, 4'b0000, 8'h00, 4'b0000, 8'h00, 4'b0000, 4'b0000, 4'b0000}, "R2 cfg b0");
    // R2: p0 arrives again without a duplicate error and completes alone
    runVec('{1'b0, 2'd0, 4'b0000, 4'b0001, 8'h00, 4'b0001, 8'h00, 4'b0001, 4'b0001, 4'b0000}, "R2 rearrive b0");
    // R2: a same-cycle arrival on the barrier being configured is discarded
    runVec('{1'b1, 2'd3, 4'b0001, 4'b0001, 8'h03, 4'b0000, 8'h00, 4'b0000, 4'b0000, 4'b0000}, "R2 cfg wins b3");
    runVec('{1'b0, 2'd0, 4'b0000, 4'b0001, 8'h03, 4'b0000, 8'h00, 4'b0000, 4'b1000, 4'b0000}, "R2 after cfg b3");
    // R4: four simultaneous arrivals complete in a single cycle
    runVec('{1'b1, 2'd2, 4'b1111, 4'b0000, 8'h00, 4'b0000, 8'h00, 4'b0000, 4'b0000, 4'b0000}, "R4 cfg b2");
    runVec('{1'b0, 2'd0, 4'b0000, 4'b1111, 8'hAA, 4'b1000, 8'h80, 4'b1000, 4'b0100, 4'b0000}, "R4 all at once");
    // R5: dropping the wait drops the release
    runVec('{1'b0, 2'd0, 4'b0000, 4'b0000, 8'h00, 4'b0000, 8'h80, 4'b0000, 4'b0000, 4'b0000}, "R5 wait dropped");

    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule